// File: doc/BRIEF.md
# Fractional Pixel Clock Divider

This block derives a display pixel clock from a faster input clock. The divide ratio has an integer part and a sixteenths fraction. The fraction is spread over successive output periods by a phase accumulator: most periods last the integer number of input cycles, and the periods in which the accumulator overflows last one cycle longer. The long-run average period is therefore the integer plus the fraction.

Inside each period the rising and falling edges sit at programmable positions counted in half input-clock steps. To carry that resolution the clock leaves the block as a pair of levels per input cycle, one for the first half of the cycle and one for the second. A double-data-rate output cell outside the block serializes the pair. Two one-cycle strobes, one at the start of each period and one at its middle, drive the display timing counters.

Software writes two configuration words through a single-cycle write port, a ratio word and an edge word. Each word is captured into a pending copy. The running copy is reloaded only where one period ends and the next begins, so no output pulse is ever cut short.

Top module: `pclk_frac_div`

## Requirements
- R1: After reset the block runs as if the ratio word held 0x010 (integer 1, fraction 0) and the edge word held rise 0, fall 1. Every period is one input cycle long, pixHalves reads 2'b01, and periodTick and halfTick are both high in every cycle.
- R2: A write with wrSel = 0 loads the ratio word. The integer part is wrData[11:4] and the fraction is wrData[3:0]. With fraction 0, every period lasts exactly the integer number of input cycles.
- R3: An integer part of 0 behaves as an integer part of 1, with the fraction still applied.
- R4: At each period start the fraction is added to a 4-bit accumulator. A carry out of the accumulator makes that period one input cycle longer. Any 16 consecutive periods therefore total 16 times the integer plus the fraction, and each single period is either the integer or the integer plus one.
- R5: A write with wrSel = 1 loads the edge word, with the rise position in wrData[8:0] and the fall position in wrData[24:16], both counted in half input-cycle steps from the period start. Within a period, half-step h is high when rise <= h < fall if rise < fall. If rise > fall, h is high when h >= rise or h < fall. If rise equals fall, the clock is always low. In input cycle c of the period, pixHalves[0] shows half-step 2c and pixHalves[1] shows half-step 2c+1.
- R6: Rise 0 with fall equal to the integer part gives a 50% duty cycle: in every period of integer length I, exactly I of the 2I half-steps are high.
- R7: A written word takes effect at the first period start that follows the clock edge capturing the write. A write captured on the same edge that ends a period is applied one period later, and the period then running is never shortened or lengthened by it.
- R8: periodTick is high for exactly one input cycle, the first cycle of every period.
- R9: halfTick is high for exactly one input cycle per period, in cycle floor(L/2) of a period of length L. With L = 1 this cycle coincides with periodTick.
- R10: Write-data bits outside the named fields (wrData[15:12] and wrData[31:25]) have no effect on the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input (fast) clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Write strobe for the configuration port |
| wrSel | input | 1 | 0 selects the ratio word, 1 selects the edge word |
| wrData | input | 32 | Configuration write data |
| pixHalves | output | 2 | Pixel clock level for the first [0] and second [1] half of the current input cycle |
| periodTick | output | 1 | One-cycle strobe at the first cycle of each pixel period |
| halfTick | output | 1 | One-cycle strobe at the middle cycle of each pixel period |

## Verification
Integer-only ratios (7, 20, 5) show that the period length follows the integer field alone. Fractional ratios (3 + 4/16, 0 + 8/16 and the 255 + 15/16 maximum) show the accumulator's stretching pattern, and a 16-period sum separates a correct carry from one that is lost or doubled. Edge words with rise below fall, rise above fall (wrap-around) and rise equal to fall separate the three level rules, and the 50% setting checks half-step counting. Writes placed mid-period and in the very last cycle of a period separate boundary-aligned loading from immediate loading or from loading at the capturing edge.

// File: rtl/pclk_pkg.sv
package pclk_pkg;

  // Strobes from the control half to the datapath half.
  typedef struct packed {
    logic boundary;  // current cycle is the last of the period
    logic startCyc;  // current cycle is the first of the period
    logic halfCyc;   // current cycle is the middle of the period
  } pclkStrobe_t;

  localparam int unsigned RESET_INT  = 1;
  localparam int unsigned RESET_FRAC = 0;
  localparam int unsigned RESET_RISE = 0;
  localparam int unsigned RESET_FALL = 1;

endpackage

// File: rtl/pclk_ctrl.sv
module pclk_ctrl
  import pclk_pkg::*;
#(
  parameter int INT_W    = 8,
  parameter int FRAC_W   = 4,
  parameter int POS_W    = 9,
  parameter int DATA_W   = 32,
  parameter int FALL_LSB = 16,
  localparam int RATIO_W = INT_W + FRAC_W,
  localparam int LEN_W   = INT_W + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              wrSel,
  input  logic [DATA_W-1:0] wrData,
  input  logic [LEN_W-1:0]  lenCur,
  output logic [INT_W-1:0]  pendInt,
  output logic [FRAC_W-1:0] pendFrac,
  output logic [POS_W-1:0]  pendRise,
  output logic [POS_W-1:0]  pendFall,
  output logic [LEN_W-1:0]  cycIdx,
  output pclkStrobe_t       strobes
);

  logic [LEN_W-1:0] lastIdx;
  logic [LEN_W-1:0] midIdx;
  logic             unusedWrBits;

  // Pending copies of both configuration words.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendInt  <= INT_W'(RESET_INT);
      pendFrac <= FRAC_W'(RESET_FRAC);
      pendRise <= POS_W'(RESET_RISE);
      pendFall <= POS_W'(RESET_FALL);
    end else if (wrEn) begin
      if (!wrSel) begin
        pendInt  <= wrData[RATIO_W-1:FRAC_W];
        pendFrac <= wrData[FRAC_W-1:0];
      end else begin
        pendRise <= wrData[POS_W-1:0];
        pendFall <= wrData[FALL_LSB+POS_W-1:FALL_LSB];
      end
    end
  end

  assign unusedWrBits = ^{wrData[DATA_W-1:FALL_LSB+POS_W], wrData[FALL_LSB-1:RATIO_W]};

  // Position inside the current period.
  assign lastIdx = lenCur - LEN_W'(1);
  assign midIdx  = lenCur >> 1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cycIdx <= '0;
    end else if (cycIdx == lastIdx) begin
      cycIdx <= '0;
    end else begin
      cycIdx <= cycIdx + LEN_W'(1);
    end
  end

  always_comb begin
    strobes          = '0;
    strobes.boundary = (cycIdx == lastIdx);
    strobes.startCyc = (cycIdx == '0);
    strobes.halfCyc  = (cycIdx == midIdx);
  end

endmodule

// File: rtl/pclk_dp.sv
module pclk_dp
  import pclk_pkg::*;
#(
  parameter int INT_W  = 8,
  parameter int FRAC_W = 4,
  parameter int POS_W  = 9,
  localparam int LEN_W = INT_W + 1,
  localparam int HS_W  = INT_W + 2,
  localparam int SUM_W = FRAC_W + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  pclkStrobe_t       strobes,
  input  logic [LEN_W-1:0]  cycIdx,
  input  logic [INT_W-1:0]  pendInt,
  input  logic [FRAC_W-1:0] pendFrac,
  input  logic [POS_W-1:0]  pendRise,
  input  logic [POS_W-1:0]  pendFall,
  output logic [LEN_W-1:0]  lenCur,
  output logic [POS_W-1:0]  riseAct,
  output logic [POS_W-1:0]  fallAct,
  output logic [1:0]        pixHalves,
  output logic              periodTick,
  output logic              halfTick
);

  logic [FRAC_W-1:0] phaseAcc;
  logic [SUM_W-1:0]  phaseSum;
  logic [INT_W-1:0]  intEff;
  logic [LEN_W-1:0]  lenNext;
  logic [HS_W-1:0]   cycBase;
  logic              edgeWrap;

  // Integer 0 is promoted to 1; carry of the accumulator stretches the period.
  assign intEff   = (pendInt == '0) ? INT_W'(1) : pendInt;
  assign phaseSum = {1'b0, phaseAcc} + {1'b0, pendFrac};
  assign lenNext  = LEN_W'(intEff) + LEN_W'(phaseSum[FRAC_W]);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phaseAcc <= '0;
      lenCur   <= LEN_W'(RESET_INT);
      riseAct  <= POS_W'(RESET_RISE);
      fallAct  <= POS_W'(RESET_FALL);
    end else if (strobes.boundary) begin
      phaseAcc <= phaseSum[FRAC_W-1:0];
      lenCur   <= lenNext;
      riseAct  <= pendRise;
      fallAct  <= pendFall;
    end
  end

  // Waveform: one level for each half of the current input cycle.
  assign cycBase  = {cycIdx, 1'b0};
  assign edgeWrap = (riseAct > fallAct);

  for (genvar k = 0; k < 2; k++) begin : g_half
    logic [HS_W-1:0] halfStep;
    logic            pastRise;
    logic            pastFall;
    assign halfStep     = cycBase + HS_W'(k);
    assign pastRise     = (halfStep >= HS_W'(riseAct));
    assign pastFall     = (halfStep >= HS_W'(fallAct));
    assign pixHalves[k] = pastRise ^ pastFall ^ edgeWrap;
  end

  assign periodTick = strobes.startCyc;
  assign halfTick   = strobes.halfCyc;

endmodule

// File: rtl/pclk_frac_div.sv
module pclk_frac_div
  import pclk_pkg::*;
#(
  parameter int INT_W    = 8,
  parameter int FRAC_W   = 4,
  parameter int POS_W    = 9,
  parameter int DATA_W   = 32,
  parameter int FALL_LSB = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              wrSel,
  input  logic [DATA_W-1:0] wrData,
  output logic [1:0]        pixHalves,
  output logic              periodTick,
  output logic              halfTick
);

  localparam int LEN_W = INT_W + 1;

  pclkStrobe_t       strobes;
  logic [LEN_W-1:0]  cycIdx;
  logic [LEN_W-1:0]  lenCur;
  logic [INT_W-1:0]  pendInt;
  logic [FRAC_W-1:0] pendFrac;
  logic [POS_W-1:0]  pendRise;
  logic [POS_W-1:0]  pendFall;
  logic [POS_W-1:0]  riseAct;
  logic [POS_W-1:0]  fallAct;

  pclk_ctrl #(
    .INT_W(INT_W), .FRAC_W(FRAC_W), .POS_W(POS_W),
    .DATA_W(DATA_W), .FALL_LSB(FALL_LSB)
  ) uCtrl (
    .clk(clk), .rstN(rstN),
    .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData),
    .lenCur(lenCur),
    .pendInt(pendInt), .pendFrac(pendFrac),
    .pendRise(pendRise), .pendFall(pendFall),
    .cycIdx(cycIdx), .strobes(strobes)
  );

  pclk_dp #(
    .INT_W(INT_W), .FRAC_W(FRAC_W), .POS_W(POS_W)
  ) uDp (
    .clk(clk), .rstN(rstN),
    .strobes(strobes), .cycIdx(cycIdx),
    .pendInt(pendInt), .pendFrac(pendFrac),
    .pendRise(pendRise), .pendFall(pendFall),
    .lenCur(lenCur), .riseAct(riseAct), .fallAct(fallAct),
    .pixHalves(pixHalves), .periodTick(periodTick), .halfTick(halfTick)
  );

endmodule

// File: rtl/pclk_frac_div_chk.sv
module pclk_frac_div_chk #(
  parameter int LEN_W = 9,
  parameter int POS_W = 9
) (
  input logic             clk,
  input logic             rstN,
  input logic [1:0]       pixHalves,
  input logic             periodTick,
  input logic             halfTick,
  input logic [LEN_W-1:0] lenCur,
  input logic [POS_W-1:0] riseAct,
  input logic [POS_W-1:0] fallAct
);

  localparam logic [LEN_W:0] MAX_LEN = LEN_W'(1) << (LEN_W - 1);

  logic [LEN_W:0] sinceTick;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           sinceTick <= '0;
    else if (periodTick) sinceTick <= (LEN_W+1)'(1);
    else                 sinceTick <= sinceTick + (LEN_W+1)'(1);
  end

  // R3: the running period length is never zero
  p_len_nonzero_r3: assert property (@(posedge clk) disable iff (!rstN)
    lenCur != '0);

  // R4: a period is at most the largest integer plus one stretched cycle
  p_len_bound_r4: assert property (@(posedge clk) disable iff (!rstN)
    {1'b0, lenCur} <= MAX_LEN);

  // R7: running configuration changes only where a new period starts
  p_cfg_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    !periodTick |-> ($stable(riseAct) && $stable(fallAct) && $stable(lenCur)));

  // R8: no period runs past its length without a tick
  p_tick_gap_r8: assert property (@(posedge clk) disable iff (!rstN)
    !periodTick |-> (sinceTick < {1'b0, lenCur}));

  // R5: equal edge positions hold the clock low
  p_flat_r5: assert property (@(posedge clk) disable iff (!rstN)
    (riseAct == fallAct) |-> (pixHalves == 2'b00));

  // R9: for periods longer than one cycle the middle strobe never meets the start strobe
  p_half_apart_r9: assert property (@(posedge clk) disable iff (!rstN)
    (halfTick && (lenCur > LEN_W'(1))) |-> !periodTick);

endmodule

bind pclk_frac_div pclk_frac_div_chk #(.LEN_W(INT_W + 1), .POS_W(POS_W)) uChk (
  .clk(clk), .rstN(rstN), .pixHalves(pixHalves),
  .periodTick(periodTick), .halfTick(halfTick),
  .lenCur(lenCur), .riseAct(riseAct), .fallAct(fallAct)
);

// File: tb/sim_pclk_frac_div.sv
module sim_pclk_frac_div;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic        wrSel = 1'b0;
  logic [31:0] wrData = '0;
  logic [1:0]  pixHalves;
  logic        periodTick;
  logic        halfTick;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pclk_frac_div u0 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData),
    .pixHalves(pixHalves), .periodTick(periodTick), .halfTick(halfTick)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int mPendInt, mPendFrac, mPendRise, mPendFall;
  int mRise, mFall, mAcc, mLen, mIdx;

  function automatic int lvl(int h, int r, int f);
    return (((h >= r) ? 1 : 0) ^ ((h >= f) ? 1 : 0) ^ ((r > f) ? 1 : 0));
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mPendInt = 1; mPendFrac = 0; mPendRise = 0; mPendFall = 1;
      mRise = 0; mFall = 1; mAcc = 0; mLen = 1; mIdx = 0;
    end else begin
      if (mIdx == mLen - 1) begin
        int ni, s;
        ni = (mPendInt == 0) ? 1 : mPendInt;
        s = mAcc + mPendFrac;
        mAcc = s % 16;
        mLen = ni + s / 16;
        mRise = mPendRise;
        mFall = mPendFall;
        mIdx = 0;
      end else begin
        mIdx++;
      end
      if (wrEn) begin
        if (!wrSel) begin
          mPendInt = (wrData >> 4) & 255;
          mPendFrac = wrData & 15;
        end else begin
          mPendRise = wrData & 511;
          mPendFall = (wrData >> 16) & 511;
        end
      end
    end
  end

  // Compare every cycle, away from the active edge.
  always @(negedge clk) begin
    if (rstN) begin
      int e0, e1;
      e0 = lvl(2*mIdx, mRise, mFall);
      e1 = lvl(2*mIdx + 1, mRise, mFall);
      chk(pixHalves == 2'(e0 | (e1 << 1)), "R5", "pixHalves", pixHalves, e0 | (e1 << 1));
      chk(periodTick == (mIdx == 0), "R8", "periodTick", periodTick, mIdx == 0);
      chk(halfTick == (mIdx == mLen/2), "R9", "halfTick", halfTick, mIdx == mLen/2);
    end
  end

  // Log of period lengths, measured at the ports.
  int lenLog[$];
  int sinceTick = 0;
  bit haveTick = 0;
  always @(negedge clk) begin
    if (!rstN) begin
      sinceTick = 0; haveTick = 0;
    end else if (periodTick) begin
      if (haveTick) lenLog.push_back(sinceTick);
      haveTick = 1; sinceTick = 1;
    end else begin
      sinceTick++;
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic step();
    @(negedge clk); #1;
  endtask

  task automatic writeWord(input bit sel, input logic [31:0] data);
    wrEn = 1'b1; wrSel = sel; wrData = data;
    step();
    wrEn = 1'b0; wrData = '0;
  endtask

  task automatic waitTick();
    step();
    while (!periodTick) step();
  endtask

  task automatic settle();
    repeat (3) waitTick();
  endtask

  task automatic collect(input int n);
    lenLog.delete();
    while (lenLog.size() < n) step();
  endtask

  task automatic highsOnePeriod(output int highs);
    waitTick();
    highs = 0;
    do begin
      highs += int'(pixHalves[0]) + int'(pixHalves[1]);
      step();
    end while (!periodTick);
  endtask

  // ---------------- directed sequence ----------------
  initial begin
    int h, sum;
    bit ok;
    repeat (3) step();
    rstN = 1'b1;
    step();
    // R1 reset state
    chk(pixHalves == 2'b01, "R1", "reset pixHalves", pixHalves, 1);
    chk(periodTick == 1'b1, "R1", "reset periodTick", periodTick, 1);
    chk(halfTick == 1'b1, "R1", "reset halfTick", halfTick, 1);
    collect(3);
    chk(lenLog[0] == 1 && lenLog[2] == 1, "R1", "reset period", lenLog[0], 1);

    // R2 integer ratio 7
    writeWord(1'b0, 32'h0000_0070);
    settle();
    collect(3);
    chk(lenLog[0] == 7 && lenLog[1] == 7 && lenLog[2] == 7, "R2", "period int 7", lenLog[1], 7);

    // R6 50% duty with integer 4
    writeWord(1'b0, 32'h0000_0040);
    writeWord(1'b1, 32'h0004_0000);
    settle();
    highsOnePeriod(h);
    chk(h == 4, "R6", "high half-steps of 8", h, 4);

    // R4 fraction 3 + 4/16
    writeWord(1'b0, 32'h0000_0034);
    settle();
    collect(16);
    sum = 0; ok = 1;
    foreach (lenLog[i]) begin
      sum += lenLog[i];
      if (lenLog[i] != 3 && lenLog[i] != 4) ok = 0;
    end
    chk(sum == 52, "R4", "16-period sum", sum, 52);
    chk(ok, "R4", "each period 3 or 4", ok, 1);

    // R5 wrapped edges: rise 9, fall 3 with integer 6
    writeWord(1'b0, 32'h0000_0060);
    writeWord(1'b1, 32'h0003_0009);
    settle();
    highsOnePeriod(h);
    chk(h == 6, "R5", "wrapped high half-steps", h, 6);

    // R5 equal edges
    writeWord(1'b1, 32'h0004_0004);
    settle();
    highsOnePeriod(h);
    chk(h == 0, "R5", "equal edges high half-steps", h, 0);

    // R3 integer 0 with fraction 8/16
    writeWord(1'b1, 32'h0001_0000);
    writeWord(1'b0, 32'h0000_0008);
    settle();
    collect(4);
    sum = lenLog[0] + lenLog[1] + lenLog[2] + lenLog[3];
    chk(sum == 6, "R3", "4-period sum int0 frac8", sum, 6);
    writeWord(1'b0, 32'h0000_0000);
    settle();
    collect(3);
    chk(lenLog[0] == 1 && lenLog[2] == 1, "R3", "int0 period", lenLog[1], 1);

    // R10 junk bits ignored: ratio int 5, edge rise 0 fall 4
    writeWord(1'b0, 32'hFFFF_F050);
    writeWord(1'b1, 32'hFE04_FE00);
    settle();
    collect(2);
    chk(lenLog[0] == 5 && lenLog[1] == 5, "R10", "period with junk bits", lenLog[0], 5);
    highsOnePeriod(h);
    chk(h == 4, "R10", "high half-steps with junk bits", h, 4);

    // R7 mid-period write
    writeWord(1'b0, 32'h0000_0140);
    settle();
    waitTick();
    lenLog.delete();
    repeat (5) step();
    writeWord(1'b0, 32'h0000_0020);
    while (lenLog.size() < 3) step();
    chk(lenLog[0] == 20, "R7", "period running during write", lenLog[0], 20);
    chk(lenLog[1] == 2 && lenLog[2] == 2, "R7", "period after write", lenLog[1], 2);

    // R7 write captured on the closing edge of a period
    writeWord(1'b0, 32'h0000_0140);
    settle();
    waitTick();
    lenLog.delete();
    repeat (19) step();
    writeWord(1'b0, 32'h0000_0030);
    while (lenLog.size() < 3) step();
    chk(lenLog[0] == 20 && lenLog[1] == 20, "R7", "last-cycle write deferred", lenLog[1], 20);
    chk(lenLog[2] == 3, "R7", "last-cycle write applied", lenLog[2], 3);

    // R4 maximum ratio 255 + 15/16
    writeWord(1'b0, 32'h0000_0FFF);
    settle();
    collect(2);
    chk((lenLog[0] == 255 || lenLog[0] == 256) && (lenLog[1] == 255 || lenLog[1] == 256),
        "R4", "max ratio period", lenLog[0], 256);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule